// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of a small, fully associative set of cache lines for one core. The system it sits in has several such controllers on one shared, arbitrated bus. Each cached line carries one of four states: invalid, shared, exclusive or modified. The controller takes one local read or write at a time. When the local state cannot satisfy the request, it requests the bus and runs a line read, a read-for-ownership or a writeback.

The controller also watches the transaction that currently holds the bus, which is the snoop input. When that transaction belongs to another controller and names an address it caches, it demotes or drops its copy of the line. It raises a hit flag so that the requester can fill as shared. If its copy is modified, it puts the dirty data on a flush output in the same cycle.

Each line holds one data word. When the controller must replace a line, it uses a free line if there is one and otherwise a rotating victim pointer. A modified victim is written back before the new line is fetched.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid: `bus_req` and `resp_valid` are low, and a snoop of any address gives `snp_hit` low.
- R2: A local read that hits a line in shared, exclusive or modified state raises `resp_valid` with the stored word in the cycle after acceptance, and raises no bus request.
- R3: A local read miss issues a bus read (`bus_op` = 1) for the request address. On completion the line fills with `bus_rdata`, as shared if `bus_shared` was high and as exclusive otherwise. The read data is returned in the cycle after completion.
- R4: A local write to an exclusive or modified line completes in the cycle after acceptance without a bus transaction. The line becomes modified and holds the written word.
- R5: A local write to a shared or absent line first issues a read-for-ownership (`bus_op` = 2). On completion the line becomes modified with the written word, and the response follows one cycle later.
- R6: A snooped read-for-ownership (`snp_op` = 2) that hits a line invalidates it, so a later local read of that address misses.
- R7: A snooped read (`snp_op` = 1) that hits an exclusive or modified line moves it to shared, so a later local write needs a read-for-ownership. A modified line hit by a snooped read or read-for-ownership raises `snp_wb_valid` with its data in the snoop cycle.
- R8: `snp_hit` is high exactly in a cycle where `snp_valid` is high and `snp_addr` matches a valid line.
- R9: A miss with no free line replaces the line at the rotating victim pointer, which starts at line 0 and advances by one on each such replacement. A modified victim is first written back (`bus_op` = 3) with its address and data, and the fetch follows. A clean victim is dropped without a writeback.
- R10: Once raised, `bus_req` stays high, with `bus_op` and `bus_addr` unchanged, until a cycle with both `bus_gnt` and `bus_done` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present, held until response |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address of the request |
| req_wdata | input | DATA_W | Write word |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | DATA_W | Read word, or written word for writes |
| bus_req | output | 1 | Bus transaction pending |
| bus_op | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 writeback |
| bus_addr | output | ADDR_W | Address of pending transaction |
| bus_wdata | output | DATA_W | Writeback word |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_done | input | 1 | Completion pulse of the granted transaction |
| bus_rdata | input | DATA_W | Fill word at completion |
| bus_shared | input | 1 | Another controller holds the line, at completion |
| snp_valid | input | 1 | Foreign transaction on the bus |
| snp_op | input | 2 | Its operation, same coding as `bus_op` |
| snp_addr | input | ADDR_W | Its address |
| snp_hit | output | 1 | This controller holds the snooped line |
| snp_wb_valid | output | 1 | Dirty data supplied for the snooped line |
| snp_wb_data | output | DATA_W | The dirty word |

## Verification
The bench walks one line through every state change. A silent upgrade from exclusive that still used the bus, or a shared line written without an ownership request, would show as an unexpected or missing bus request. A snooped read that left a modified line owned would skip the later ownership request. A missing flush would leave the written word off `snp_wb_data`. The eviction case fills all lines, then checks that the clean victim goes without a writeback and that the dirty one is written back with its own address before the fetch. A wrong victim order or a skipped writeback gives the wrong bus address or operation.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_RFO = 2'd2, OP_WB = 2'd3} busop_t;

  function automatic logic can_write(input mesi_t s);
    return (s == ST_E) || (s == ST_M);
  endfunction

  function automatic mesi_t fill_state(input busop_t op, input logic shared);
    if (op == OP_RFO) return ST_M;
    return shared ? ST_S : ST_E;
  endfunction

  function automatic mesi_t snoop_next(input mesi_t s, input busop_t op);
    case (op)
      OP_RD:   return can_write(s) ? ST_S : s;
      OP_RFO:  return ST_I;
      default: return s;
    endcase
  endfunction

  function automatic logic snoop_flush(input mesi_t s, input busop_t op);
    return (s == ST_M) && (op == OP_RD || op == OP_RFO);
  endfunction
endpackage

// File: rtl/mesi_tag_match.sv
module mesi_tag_match #(
  parameter int NLINES = 4,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic [NLINES-1:0][ADDR_W-1:0] tags,
  input  logic [NLINES-1:0]             valid,
  input  logic [ADDR_W-1:0]             addr,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (valid[i] && tags[i] == addr) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mesi_victim_pick.sv
module mesi_victim_pick #(
  parameter int NLINES = 4,
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] valid,
  input  logic              step,
  output logic [IDX_W-1:0]  idx,
  output logic              full
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NLINES - 1);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign full = &valid;
  assign idx  = full ? ptr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (step) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_wb_valid,
  output logic [DATA_W-1:0] snp_wb_data
);
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_FILL, F_RESP} fsm_t;

  mesi_t                       st_q [NLINES];
  logic [NLINES-1:0][ADDR_W-1:0] tag_q;
  logic [NLINES-1:0][DATA_W-1:0] dat_q;
  logic [NLINES-1:0]           vld;

  fsm_t             fsm_q;
  logic [IDX_W-1:0] line_q;
  busop_t           op_q;
  logic [DATA_W-1:0] resp_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_vld
    assign vld[g] = (st_q[g] != ST_I);
  end

  logic             loc_hit, snp_match, vic_full;
  logic [IDX_W-1:0] loc_idx, snp_idx, vic_idx;

  mesi_tag_match #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_loc_match (
    .tags(tag_q), .valid(vld), .addr(req_addr), .hit(loc_hit), .idx(loc_idx));

  mesi_tag_match #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_snp_match (
    .tags(tag_q), .valid(vld), .addr(snp_addr), .hit(snp_match), .idx(snp_idx));

  // named internal events
  busop_t snp_kind;
  mesi_t  loc_state, snp_state;
  logic   accept, ev_rd_hit, ev_wr_hit, ev_upgrade, ev_miss, xact_done, ev_vic_step;

  assign snp_kind    = busop_t'(snp_op);
  assign loc_state   = st_q[loc_idx];
  assign snp_state   = st_q[snp_idx];
  assign accept      = (fsm_q == F_IDLE) && req_valid && !snp_valid;
  assign ev_rd_hit   = accept && !req_write && loc_hit;
  assign ev_wr_hit   = accept && req_write && loc_hit && can_write(loc_state);
  assign ev_upgrade  = accept && req_write && loc_hit && !can_write(loc_state);
  assign ev_miss     = accept && !loc_hit;
  assign ev_vic_step = ev_miss && vic_full;
  assign xact_done   = bus_req && bus_gnt && bus_done;

  mesi_victim_pick #(.NLINES(NLINES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(vld), .step(ev_vic_step),
    .idx(vic_idx), .full(vic_full));

  // snoop response
  assign snp_hit      = snp_valid && snp_match;
  assign snp_wb_valid = snp_hit && snoop_flush(snp_state, snp_kind);
  assign snp_wb_data  = dat_q[snp_idx];

  // bus master side
  assign bus_req   = (fsm_q == F_EVICT) || (fsm_q == F_FILL);
  assign bus_op    = (fsm_q == F_EVICT) ? OP_WB : (fsm_q == F_FILL) ? op_q : OP_NONE;
  assign bus_addr  = (fsm_q == F_EVICT) ? tag_q[line_q] : req_addr;
  assign bus_wdata = (fsm_q == F_EVICT) ? dat_q[line_q] : '0;

  assign resp_valid = (fsm_q == F_RESP);
  assign resp_rdata = resp_q;

  // line storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st_q[i] <= ST_I;
      tag_q <= '0;
      dat_q <= '0;
    end else begin
      if (snp_hit) st_q[snp_idx] <= snoop_next(snp_state, snp_kind);
      if (ev_wr_hit) begin
        st_q[loc_idx]  <= ST_M;
        dat_q[loc_idx] <= req_wdata;
      end
      if (fsm_q == F_EVICT && xact_done) st_q[line_q] <= ST_I;
      if (fsm_q == F_FILL && xact_done) begin
        tag_q[line_q] <= req_addr;
        st_q[line_q]  <= fill_state(op_q, bus_shared);
        dat_q[line_q] <= (op_q == OP_RFO) ? req_wdata : bus_rdata;
      end
    end
  end

  // request sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      line_q <= '0;
      op_q   <= OP_NONE;
      resp_q <= '0;
    end else begin
      case (fsm_q)
        F_IDLE: begin
          if (ev_rd_hit) begin
            resp_q <= dat_q[loc_idx];
            fsm_q  <= F_RESP;
          end else if (ev_wr_hit) begin
            resp_q <= req_wdata;
            fsm_q  <= F_RESP;
          end else if (ev_upgrade) begin
            line_q <= loc_idx;
            op_q   <= OP_RFO;
            fsm_q  <= F_FILL;
          end else if (ev_miss) begin
            line_q <= vic_idx;
            op_q   <= req_write ? OP_RFO : OP_RD;
            fsm_q  <= (st_q[vic_idx] == ST_M) ? F_EVICT : F_FILL;
          end
        end
        F_EVICT: if (xact_done) fsm_q <= F_FILL;
        F_FILL: begin
          if (xact_done) begin
            resp_q <= (op_q == OP_RFO) ? req_wdata : bus_rdata;
            fsm_q  <= F_RESP;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_line_checker.sv
module mesi_line_checker
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_done,
  input logic [1:0]        bus_op,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              resp_valid,
  input logic              snp_valid,
  input logic              snp_hit,
  input logic              snp_wb_valid,
  input logic              ev_wr_hit,
  input mesi_t             wr_prior
);
  logic open_xact;
  assign open_xact = bus_req && !(bus_gnt && bus_done);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bus_req && !resp_valid));

  a_r2_resp_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !bus_req);

  a_r4_write_owned: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hit |-> (wr_prior == ST_E || wr_prior == ST_M));

  a_r5_rfo_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_done && bus_op == OP_RFO) |=> resp_valid);

  a_r7_flush_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb_valid |-> snp_hit);

  a_r8_hit_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |-> snp_valid);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    open_xact |=> bus_req);

  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    open_xact |=> ($stable(bus_op) && $stable(bus_addr)));
endmodule

bind mesi_line_ctrl mesi_line_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_done(bus_done), .bus_op(bus_op), .bus_addr(bus_addr),
  .resp_valid(resp_valid), .snp_valid(snp_valid), .snp_hit(snp_hit),
  .snp_wb_valid(snp_wb_valid), .ev_wr_hit(ev_wr_hit), .wr_prior(loc_state));

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        bus_req;
  logic [1:0]  bus_op;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_gnt = 1'b0, bus_done = 1'b0, bus_shared = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_op = '0;
  logic [15:0] snp_addr = '0;
  logic        snp_hit, snp_wb_valid;
  logic [31:0] snp_wb_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mesi_line_ctrl u_mesi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .bus_req(bus_req), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_wb_valid(snp_wb_valid), .snp_wb_data(snp_wb_data));

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic issue(input bit w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
  endtask

  // one cycle after acceptance: response present, bus quiet
  task automatic expect_fast(input logic [31:0] exp, input string what);
    @(negedge clk);
    chk(resp_valid == 1'b1, {what, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk(bus_req == 1'b0, {what, " no bus request"}, 32'(bus_req), 32'd0);
    chk(resp_rdata == exp, {what, " data"}, resp_rdata, exp);
    req_valid = 1'b0;
  endtask

  task automatic serve(input logic [1:0] op, input logic [15:0] a, input bit chk_wd,
                       input logic [31:0] wd, input logic [31:0] rd, input bit sh, input string what);
    int n = 0;
    while (!bus_req && n < 40) begin @(negedge clk); n++; end
    chk(bus_req == 1'b1, {what, " bus_req"}, 32'(bus_req), 32'd1);
    chk(bus_op == op, {what, " bus_op"}, 32'(bus_op), 32'(op));
    chk(bus_addr == a, {what, " bus_addr"}, 32'(bus_addr), 32'(a));
    if (chk_wd) chk(bus_wdata == wd, {what, " bus_wdata"}, bus_wdata, wd);
    bus_gnt = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b1 && bus_op == op, {what, " R10 request held"}, 32'(bus_op), 32'(op));
    bus_done = 1'b1; bus_rdata = rd; bus_shared = sh;
    @(negedge clk);
    bus_done = 1'b0; bus_gnt = 1'b0; bus_shared = 1'b0;
  endtask

  task automatic get_resp(input logic [31:0] exp, input string what);
    int n = 0;
    while (!resp_valid && n < 40) begin @(negedge clk); n++; end
    chk(resp_valid == 1'b1, {what, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk(resp_rdata == exp, {what, " data"}, resp_rdata, exp);
    req_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [15:0] a, input bit hit,
                       input bit wb, input logic [31:0] wd, input string what);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    #1;
    chk(snp_hit == hit, {what, " snp_hit"}, 32'(snp_hit), 32'(hit));
    chk(snp_wb_valid == wb, {what, " snp_wb_valid"}, 32'(snp_wb_valid), 32'(wb));
    if (wb) chk(snp_wb_data == wd, {what, " snp_wb_data"}, snp_wb_data, wd);
    @(negedge clk);
    snp_valid = 1'b0; snp_op = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_req == 1'b0, "R1 bus_req after reset", 32'(bus_req), 32'd0);
    chk(resp_valid == 1'b0, "R1 resp_valid after reset", 32'(resp_valid), 32'd0);
    snoop(2'd1, 16'h0010, 1'b0, 1'b0, 32'h0, "R1 empty snoop");
  endtask

  task automatic t_line_walk();
    issue(1'b0, 16'h0010, 32'h0);
    serve(2'd1, 16'h0010, 1'b0, 32'h0, 32'hA0A0_0001, 1'b0, "R3 read miss");
    get_resp(32'hA0A0_0001, "R3 fill data");
    issue(1'b1, 16'h0010, 32'h1111_0001);
    expect_fast(32'h1111_0001, "R4 silent write to exclusive");
    snoop(2'd1, 16'h0010, 1'b1, 1'b1, 32'h1111_0001, "R7 R8 snooped read of modified");
    issue(1'b1, 16'h0010, 32'h1111_0002);
    serve(2'd2, 16'h0010, 1'b0, 32'h0, 32'h0, 1'b0, "R7 R5 write after demotion");
    get_resp(32'h1111_0002, "R5 rfo write");
    snoop(2'd2, 16'h0010, 1'b1, 1'b1, 32'h1111_0002, "R6 snooped rfo of modified");
    issue(1'b0, 16'h0010, 32'h0);
    serve(2'd1, 16'h0010, 1'b0, 32'h0, 32'hA0A0_0002, 1'b0, "R6 read after invalidate");
    get_resp(32'hA0A0_0002, "R6 refill data");
  endtask

  task automatic t_shared();
    issue(1'b0, 16'h0020, 32'h0);
    serve(2'd1, 16'h0020, 1'b0, 32'h0, 32'hB0B0_0001, 1'b1, "R3 read miss with sharer");
    get_resp(32'hB0B0_0001, "R3 shared fill data");
    issue(1'b0, 16'h0020, 32'h0);
    expect_fast(32'hB0B0_0001, "R2 read hit on shared");
    issue(1'b1, 16'h0020, 32'h2222_0001);
    serve(2'd2, 16'h0020, 1'b0, 32'h0, 32'h0, 1'b0, "R5 write to shared");
    get_resp(32'h2222_0001, "R5 upgrade write");
    issue(1'b0, 16'h0020, 32'h0);
    expect_fast(32'h2222_0001, "R2 read hit on modified");
    snoop(2'd1, 16'h0099, 1'b0, 1'b0, 32'h0, "R8 snoop miss");
  endtask

  task automatic t_evict();
    issue(1'b0, 16'h0030, 32'h0);
    serve(2'd1, 16'h0030, 1'b0, 32'h0, 32'hC0C0_0001, 1'b0, "R9 fill third line");
    get_resp(32'hC0C0_0001, "R9 third line data");
    issue(1'b0, 16'h0040, 32'h0);
    serve(2'd1, 16'h0040, 1'b0, 32'h0, 32'hD0D0_0001, 1'b0, "R9 fill fourth line");
    get_resp(32'hD0D0_0001, "R9 fourth line data");
    // full: victim line 0 (clean exclusive, address 0x10) dropped silently
    issue(1'b0, 16'h0050, 32'h0);
    serve(2'd1, 16'h0050, 1'b0, 32'h0, 32'hE0E0_0001, 1'b0, "R9 clean victim no writeback");
    get_resp(32'hE0E0_0001, "R9 fill over clean victim");
    // next victim line 1 (modified, address 0x20) written back first
    issue(1'b0, 16'h0060, 32'h0);
    serve(2'd3, 16'h0020, 1'b1, 32'h2222_0001, 32'h0, 1'b0, "R9 dirty victim writeback");
    serve(2'd1, 16'h0060, 1'b0, 32'h0, 32'hF0F0_0001, 1'b0, "R9 fetch after writeback");
    get_resp(32'hF0F0_0001, "R9 fill over dirty victim");
    snoop(2'd1, 16'h0010, 1'b0, 1'b0, 32'h0, "R9 first victim gone");
    snoop(2'd1, 16'h0020, 1'b0, 1'b0, 32'h0, "R9 second victim gone");
    snoop(2'd1, 16'h0030, 1'b1, 1'b0, 32'h0, "R9 survivor kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_line_walk();
    t_shared();
    t_evict();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %h expected %h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule